// File: doc/BRIEF.md
# SD Card SPI Byte Port

This peripheral sits on a CPU register bus and drives the SPI wires of an SD card socket. It has two byte-wide locations. The first is written as a control register, which holds the port enable, the interrupt enable and the card select. It is read back as a status register, which reports the interrupt flag and the card-present and write-protect switches of the socket. The second location is the data port. Each access to it runs one full-duplex 8-bit exchange on the bus.

Software streams a sector by reading the data port over and over. A read sends 0xFF and returns the byte that came back, so no separate start command is needed. A write sends its byte. Either kind of data access is held off by `acc_ready` until all 8 bits have moved. Back-to-back accesses therefore stay in order and cannot overrun. Dummy clocks can be sent before the card is selected by enabling the port with the select bit clear.

Top module: `sdspi_host`

## Requirements
- R1: A control write (`acc_addr`=0) takes the port enable from bit 7, the interrupt enable from bit 6 and the card select from bit 0. Bits 5 to 1 have no effect.
- R2: A status read (`acc_addr`=0) returns the interrupt flag in bit 7, `card_wp` in bit 1 and `card_present` in bit 0. Bits 6 to 2 read as zero. A control access is ready in the cycle it is presented.
- R3: A data write (`acc_addr`=1) with the port enabled sends the written byte MSB first over 8 rising SCK edges. It returns in `acc_rdata` the 8 bits sampled from `spi_miso`, first bit in bit 7.
- R4: A data read with the port enabled sends 0xFF and returns the byte received during that exchange.
- R5: `spi_cs_n` is low exactly when both enable and select are 1. Writing 0x00 to the control register raises `spi_cs_n` and disables the port.
- R6: With enable 1 and select 0, a data access still produces its 8 SCK pulses while `spi_cs_n` stays high.
- R7: SCK follows SPI mode 0. It idles low, MOSI changes only after falling edges, and the SCK period is 2*HALF_DIV system clocks.
- R8: An enabled data access is acknowledged by `acc_ready` exactly 16*HALF_DIV+1 clock edges after it is first presented. Until then `acc_ready` stays low.
- R9: When the interrupt enable is 1, the interrupt flag (and `irq`) sets at the end of each exchange. Any data access clears it. With the interrupt enable at 0, an exchange leaves the flag clear.
- R10: A data access while the port is disabled is ready at once, makes no SCK edge and returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Bus access request, held until `acc_ready` |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = control/status, 1 = data port |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid while `acc_ready` |
| acc_ready | output | 1 | Access completes in this cycle |
| card_present | input | 1 | Socket card-detect switch, 1 = card present |
| card_wp | input | 1 | Socket write-protect switch, 1 = locked |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| spi_cs_n | output | 1 | Active-low card select |
| irq | output | 1 | Interrupt flag |

## Verification
The data port is driven with random bytes, reads and writes mixed, against a card model that returns random bytes. A bit-order or sampling-edge error shows up both in the byte the model collects and in the byte the port returns. Control values are random, so exchanges run selected, deselected, disabled and with interrupts on or off. These separate the select gating, the dummy-clock case, the bypass when disabled, and the set and clear of the flag. Directed cases cover the reset state, writes with only the ignored bits set, the all-zero control write and the exact acknowledge latency.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } xfer_st_t;

  // byte returned by a status read
  function automatic logic [7:0] status_pack(input logic irq_f,
                                             input logic wp,
                                             input logic present);
    return {irq_f, 5'b00000, wp, present};
  endfunction

  // card select is driven only when the port is on and selected
  function automatic logic cs_active(input logic en, input logic sel);
    return en & sel;
  endfunction

endpackage

// File: rtl/sdspi_clkdiv.sv
module sdspi_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R7
  half_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HALF_DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/sdspi_shifter.sv
module sdspi_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       tick,
  input  logic       miso,
  output logic       busy,
  output logic       fin,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_sh;
  logic [7:0] rx_sh;
  logic [3:0] half_cnt;
  logic       rise_ev;
  logic       fall_ev;

  assign rise_ev = busy && tick && !sck;
  assign fall_ev = busy && tick && sck;
  assign fin     = fall_ev && (half_cnt == 4'd15);
  assign mosi    = tx_sh[7];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh    <= 8'hFF;
      rx_sh    <= 8'h00;
      half_cnt <= '0;
      sck      <= 1'b0;
      busy     <= 1'b0;
    end else if (start && !busy) begin
      tx_sh    <= tx_byte;
      half_cnt <= '0;
      sck      <= 1'b0;
      busy     <= 1'b1;
    end else if (busy && tick) begin
      sck      <= ~sck;
      half_cnt <= half_cnt + 1'b1;
      if (rise_ev) rx_sh <= {rx_sh[6:0], miso};
      if (fall_ev) tx_sh <= {tx_sh[6:0], 1'b1};
      if (fin)     busy  <= 1'b0;
    end
  end

  // R7
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R7
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sck && $past(busy) && $past(sck)) |-> $stable(mosi));
  // R3
  fin_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !busy && !sck);

endmodule

// File: rtl/sdspi_regs.sv
module sdspi_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wd_en,
  input  logic       wd_ie,
  input  logic       wd_sel,
  input  logic       wd_zero,
  input  logic       set_irq,
  input  logic       clr_irq,
  input  logic       card_present,
  input  logic       card_wp,
  output logic       en,
  output logic       irq_en,
  output logic       sel,
  output logic       irq_flag,
  output logic [7:0] status
);
  import sdspi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      irq_en <= 1'b0;
      sel    <= 1'b0;
    end else if (wr_ctrl) begin
      en     <= wd_en;
      irq_en <= wd_ie;
      sel    <= wd_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (set_irq) irq_flag <= 1'b1;
    else if (clr_irq) irq_flag <= 1'b0;
  end

  assign status = status_pack(irq_flag, card_wp, card_present);

  // R5
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wd_zero) |=> (!en && !sel));
  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_irq |=> irq_flag);
  // R9
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_irq && !set_irq) |=> !irq_flag);

endmodule

// File: rtl/sdspi_host.sv
module sdspi_host #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       acc_ready,
  input  logic       card_present,
  input  logic       card_wp,
  output logic       spi_sck,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n,
  output logic       irq
);
  import sdspi_pkg::*;

  xfer_st_t   state;
  logic       en, irq_en, sel, irq_flag;
  logic [7:0] status;
  logic       wr_ctrl, data_req, start_ev, bypass_ev;
  logic       tick, busy, fin;
  logic [7:0] rx_byte, tx_byte;

  assign wr_ctrl   = acc_valid && acc_write && !acc_addr;
  assign data_req  = acc_valid && acc_addr;
  assign start_ev  = data_req && en && (state == ST_IDLE);
  assign bypass_ev = data_req && !en && (state == ST_IDLE);
  assign tx_byte   = acc_write ? acc_wdata : 8'hFF;

  sdspi_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl),
    .wd_en(acc_wdata[7]), .wd_ie(acc_wdata[6]), .wd_sel(acc_wdata[0]),
    .wd_zero(acc_wdata == 8'h00),
    .set_irq(fin && irq_en), .clr_irq(start_ev || bypass_ev),
    .card_present(card_present), .card_wp(card_wp),
    .en(en), .irq_en(irq_en), .sel(sel), .irq_flag(irq_flag), .status(status)
  );

  sdspi_clkdiv #(.HALF_DIV(HALF_DIV)) div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  sdspi_shifter shf_i (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .tx_byte(tx_byte),
    .tick(tick), .miso(spi_miso), .busy(busy), .fin(fin),
    .sck(spi_sck), .mosi(spi_mosi), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: if (start_ev) state <= ST_XFER;
        ST_XFER: if (fin)      state <= ST_DONE;
        ST_DONE:               state <= ST_IDLE;
        default:               state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!acc_addr) begin
      acc_ready = acc_valid;
      acc_rdata = status;
    end else begin
      acc_ready = acc_valid && ((state == ST_DONE) || bypass_ev);
      acc_rdata = (state == ST_DONE) ? rx_byte : 8'hFF;
    end
  end

  assign spi_cs_n = !cs_active(en, sel);
  assign irq      = irq_flag;

  // R8
  xfer_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER) |=> (state != ST_IDLE));
  // R8
  done_after_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |-> $past(fin));
  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_ev && !busy) |=> !spi_sck);

endmodule

// File: tb/sdspi_host_tb.sv
module sdspi_host_tb_top;
  localparam int H   = 2;
  localparam int PER = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_addr = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic acc_ready;
  logic card_present = 1'b1, card_wp = 1'b0;
  logic spi_sck, spi_mosi, spi_miso, spi_cs_n, irq;

  always #(PER/2) clk = ~clk;

  sdspi_host #(.HALF_DIV(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_ready(acc_ready), .card_present(card_present), .card_wp(card_wp),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // card model
  logic [7:0] slv_tx = 8'h00;
  logic [7:0] slv_rx = 8'h00;
  logic [2:0] slv_cnt = 3'd0;
  int edges = 0, bad_period = 0;
  time last_rise = 0;
  assign spi_miso = slv_tx[3'd7 - slv_cnt];

  always @(posedge spi_sck) begin
    slv_rx  <= {slv_rx[6:0], spi_mosi};
    slv_cnt <= slv_cnt + 3'd1;
    if (edges > 0 && ($time - last_rise) != 2*H*PER) bad_period++;
    last_rise = $time;
    edges++;
  end

  // bench model of control state
  bit m_en = 0, m_ie = 0, m_sel = 0, m_irq = 0;
  logic [7:0] rd;
  int lat;
  logic cs_mid, irq_mid;

  function automatic logic [7:0] exp_status(bit f, bit wp, bit pr);
    logic [7:0] v = 8'h00;
    v[7] = f; v[1] = wp; v[0] = pr;
    return v;
  endfunction

  function automatic int exp_latency(bit is_data, bit en);
    return (is_data && en) ? 16*H + 1 : 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, bit addr, logic [7:0] wd);
    @(posedge clk); #1;
    acc_valid = 1; acc_write = wr; acc_addr = addr; acc_wdata = wd;
    edges = 0; bad_period = 0; lat = 0; cs_mid = spi_cs_n; irq_mid = irq;
    forever begin
      @(negedge clk);
      if (lat == 1) begin cs_mid = spi_cs_n; irq_mid = irq; end
      if (acc_ready) begin rd = acc_rdata; break; end
      lat++;
      if (lat > 1000) break;
    end
    @(posedge clk); #1;
    acc_valid = 0;
    if (!addr && wr) begin
      m_en = wd[7]; m_ie = wd[6]; m_sel = wd[0];
    end
  endtask

  task automatic data_op(bit wr, logic [7:0] wd, logic [7:0] miso_b);
    logic [7:0] sent = wr ? wd : 8'hFF;
    slv_tx = miso_b;
    access(wr, 1'b1, wd);
    @(negedge clk);
    check(lat == exp_latency(1, m_en), "R8 latency", lat, exp_latency(1, m_en));
    if (m_en) begin
      check(rd == miso_b, wr ? "R3 rx" : "R4 rx", rd, miso_b);
      check(slv_rx == sent, wr ? "R3 mosi" : "R4 mosi", slv_rx, sent);
      check(edges == 8, "R3 edges", edges, 8);
      check(bad_period == 0, "R7 period", bad_period, 0);
      check(cs_mid == !m_sel, "R6 cs during", cs_mid, !m_sel);
      check(irq_mid == 0, "R9 clear", irq_mid, 0);
      m_irq = m_ie;
    end else begin
      check(rd == 8'hFF, "R10 rdata", rd, 8'hFF);
      check(edges == 0, "R10 edges", edges, 0);
      m_irq = 0;
    end
    check(spi_sck == 0, "R7 idle", spi_sck, 0);
    check(irq == m_irq, "R9 irq", irq, m_irq);
  endtask

  task automatic status_op();
    access(1'b0, 1'b0, 8'h00);
    check(lat == 0, "R2 latency", lat, 0);
    check(rd == exp_status(m_irq, card_wp, card_present), "R2 status",
          rd, exp_status(m_irq, card_wp, card_present));
  endtask

  task automatic ctrl_op(logic [7:0] v);
    access(1'b1, 1'b0, v);
    @(negedge clk);
    check(spi_cs_n == !(m_en && m_sel), "R5 cs", spi_cs_n, !(m_en && m_sel));
  endtask

  initial begin
    #(PER*150000);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(spi_cs_n == 1, "R5 reset cs", spi_cs_n, 1);
    check(spi_sck == 0, "R7 reset sck", spi_sck, 0);
    check(irq == 0, "R9 reset irq", irq, 0);
    status_op();
    // R10 disabled access
    data_op(1'b1, 8'h5A, 8'h33);
    // R6 dummy clocks, deselected
    ctrl_op(8'h80);
    data_op(1'b0, 8'h00, 8'hC3);
    // R3 selected write
    ctrl_op(8'h81);
    data_op(1'b1, 8'hA5, 8'h3C);
    data_op(1'b1, 8'h01, 8'h80);
    // R9 interrupts, R4 read stream
    ctrl_op(8'hC1);
    data_op(1'b0, 8'h00, 8'h96);
    status_op();
    data_op(1'b0, 8'h00, 8'h01);
    // R1 ignored bits: 0xBE -> en, no irq, no select
    ctrl_op(8'hBE);
    check(spi_cs_n == 1, "R1 ignored bits", spi_cs_n, 1);
    data_op(1'b1, 8'h7E, 8'hE7);
    check(irq == 0, "R1 ignore irq", irq, 0);
    card_wp = 1; card_present = 0;
    status_op();
    // R5 zero write
    ctrl_op(8'h81);
    ctrl_op(8'h00);
    check(spi_cs_n == 1, "R5 zero", spi_cs_n, 1);
    data_op(1'b0, 8'h00, 8'h12);
    // random mix
    for (int i = 0; i < 60; i++) begin
      int op = $urandom_range(0, 9);
      card_wp = 1'($urandom); card_present = 1'($urandom);
      if (op == 0) ctrl_op({1'($urandom_range(0, 3) != 0), 7'($urandom)});
      else if (op == 1) status_op();
      else data_op(1'($urandom), 8'($urandom), 8'($urandom));
    end
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule